// File: doc/BRIEF.md
# Serial NVSRAM Transaction Monitor

This block listens to a byte-level serial bus between a host and a small nonvolatile static RAM. It never drives the bus. Another block recovers the bits and hands it completed bytes: one strobe per byte, the byte the host sent and the byte the device returned. The monitor also watches the chip-select level. From these inputs it rebuilds each transaction framed by chip select and, when the frame closes, emits a single record.

The first byte of a frame is the instruction. Its bit 7 and its three low bits select the operation, and bits 6:3 carry a word address. If the frame holds only that byte, the record describes a plain command. If more bytes follow, they are shifted into two 16-bit accumulators, one for each bus direction. The record then describes an addressed access, and its value is taken from the accumulator that matches the direction of the operation.

Each record also carries a start stamp: the value of a free-running cycle counter at the moment the instruction byte arrived. The stamp lets a trace tool place the transaction on a time axis.

Top module: `nvsram_txn_monitor`

## Requirements
- R1: The operation class comes from the instruction byte ANDed with 0x87. The class code on `rec_kind` is the low three bits of the masked byte: 0 = write-disable, 1 = store, 2 = sleep, 3 = write, 4 = write-enable, 5 = recall.
- R2: A masked instruction of 0x86 or 0x87 is reported with class code 6 (read).
- R3: An instruction byte with bit 7 clear is reported with class code 7 (unrecognised), whatever its other bits are.
- R4: For an addressed access, `rec_addr` equals bits 6:3 of the instruction byte.
- R5: A frame holding exactly one byte gives a record with `rec_addressed` = 0, `rec_addr` = 0 and `rec_value` = 0.
- R6: In a frame of two or more bytes, every byte after the instruction is shifted into both accumulators, most significant byte first. When more than two data bytes arrive, the oldest bytes fall out of the top, so the field holds the last two data bytes.
- R7: A read record reports the accumulator built from `dev_byte`. A write record reports the accumulator built from `host_byte`. Any other class reports 0.
- R8: Chip select is active high. The clock edge that first samples it high clears the byte count and both accumulators. A byte strobe sampled on that same edge counts as the instruction byte.
- R9: Byte strobes sampled while chip select is low change nothing.
- R10: The record appears with `rec_valid` high in the cycle after the first clock edge that samples chip select low following a high sample.
- R11: A frame in which no byte strobe was accepted produces no record.
- R12: `rec_start` is the value of a 16-bit cycle counter at the edge that accepts the instruction byte. The counter is 0 in the first cycle after reset, adds 1 on every clock and wraps.
- R13: `rec_valid` lasts one cycle. All record fields hold their values until the next pulse. A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip-select level, active high |
| byte_stb | input | 1 | One-cycle strobe: a complete byte is present on both data inputs |
| host_byte | input | 8 | Byte sent from host to device |
| dev_byte | input | 8 | Byte returned from device to host |
| rec_valid | output | 1 | One-cycle record pulse |
| rec_kind | output | 3 | Operation class code |
| rec_addressed | output | 1 | 1 = addressed access, 0 = plain command |
| rec_addr | output | 4 | Word address |
| rec_value | output | 16 | Data value of the access |
| rec_start | output | 16 | Cycle stamp of the instruction byte |

## Verification
The bench runs each masked opcode as a single-byte frame, plus one instruction with bit 7 clear. This shows whether the decoder separates all eight classes, including the two read aliases.

Addressed frames of two, three and five bytes use host and device bytes that differ. These frames show whether a read selects the device lane and a write the host lane, and whether excess data bytes shift out of the top. A store frame with data bytes must still report 0.

Chip-select corner patterns check the frame boundaries:
- a frame with no bytes must produce no record;
- strobes while chip select is idle must change nothing;
- a strobe on the same edge as the chip-select rise must count as the instruction byte;
- back-to-back frames must not carry data from one frame into the next.

// File: rtl/nvs_mon_pkg.sv
package nvs_mon_pkg;

   typedef enum logic [2:0] {
      K_WR_DIS  = 3'd0,
      K_STORE   = 3'd1,
      K_SLEEP   = 3'd2,
      K_WRITE   = 3'd3,
      K_WR_EN   = 3'd4,
      K_RECALL  = 3'd5,
      K_READ    = 3'd6,
      K_UNKNOWN = 3'd7
   } nvs_kind_e;

   localparam logic [7:0] OPC_MASK = 8'h87;

   // Masked opcode to class. Both read aliases fold onto K_READ.
   function automatic nvs_kind_e classify(input logic [7:0] insn);
      logic [7:0] m;
      m = insn & OPC_MASK;
      if (!m[7])
         return K_UNKNOWN;
      unique case (m[2:0])
         3'd0: return K_WR_DIS;
         3'd1: return K_STORE;
         3'd2: return K_SLEEP;
         3'd3: return K_WRITE;
         3'd4: return K_WR_EN;
         3'd5: return K_RECALL;
         default: return K_READ;
      endcase
   endfunction

endpackage

// File: rtl/nvs_insn_decode.sv
module nvs_insn_decode
   import nvs_mon_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int ADDR_LSB = 3,
   parameter int ADDR_W   = 4
) (
   input  logic [BYTE_W-1:0] insn_i,
   output nvs_kind_e         kind_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              is_read_o,
   output logic              is_write_o
);

   localparam int ADDR_MSB = ADDR_LSB + ADDR_W - 1;

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("nvs_insn_decode: BYTE_W must be 8");
      end
      if (ADDR_MSB >= BYTE_W - 1) begin : g_bad_addr
         $error("nvs_insn_decode: address field overlaps opcode bit 7");
      end
   endgenerate

   always_comb begin
      kind_o     = classify(insn_i);
      addr_o     = insn_i[ADDR_MSB:ADDR_LSB];
      is_read_o  = (kind_o == K_READ);
      is_write_o = (kind_o == K_WRITE);
   end

   // R2: both read aliases decode to the read class
   always_comb begin
      if ((insn_i & OPC_MASK) == 8'h86 || (insn_i & OPC_MASK) == 8'h87)
         a_r2_read_alias: assert (is_read_o);
   end

endmodule

// File: rtl/nvs_frame_tracker.sv
module nvs_frame_tracker #(
   parameter int BYTE_W = 8,
   parameter int TS_W   = 16,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_i,
   input  logic              stb_i,
   input  logic [BYTE_W-1:0] host_i,
   output logic              rise_o,
   output logic              data_stb_o,
   output logic              frame_end_o,
   output logic              multi_o,
   output logic [BYTE_W-1:0] insn_o,
   output logic [TS_W-1:0]   start_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("nvs_frame_tracker: CNT_W must be at least 2");
      end
      if (TS_W < 1) begin : g_bad_ts
         $error("nvs_frame_tracker: TS_W must be positive");
      end
   endgenerate

   logic              cs_q;
   logic [CNT_W-1:0]  cnt_q, cnt_eff, cnt_d;
   logic [TS_W-1:0]   ts_q;
   logic [BYTE_W-1:0] insn_q;
   logic [TS_W-1:0]   start_q;
   logic              accept, first_stb;

   always_comb begin
      rise_o      = cs_i && !cs_q;
      accept      = cs_i && stb_i;
      cnt_eff     = rise_o ? '0 : cnt_q;
      first_stb   = accept && (cnt_eff == '0);
      data_stb_o  = accept && (cnt_eff != '0);
      frame_end_o = cs_q && !cs_i && (cnt_q != '0);
      multi_o     = (cnt_q >= CNT_TWO);
      if (accept && cnt_eff != CNT_MAX)
         cnt_d = cnt_eff + CNT_ONE;
      else
         cnt_d = cnt_eff;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cs_q    <= 1'b0;
         cnt_q   <= '0;
         ts_q    <= '0;
         insn_q  <= '0;
         start_q <= '0;
      end else begin
         cs_q  <= cs_i;
         cnt_q <= cnt_d;
         ts_q  <= ts_q + TS_W'(1);
         if (first_stb) begin
            insn_q  <= host_i;
            start_q <= ts_q;
         end
      end
   end

   assign insn_o  = insn_q;
   assign start_o = start_q;

   // R9: strobes while deselected leave the byte count alone
   a_r9_idle_strobe: assert property (@(posedge clk) disable iff (rst)
      (!cs_i && stb_i) |=> $stable(cnt_q));

   // R8: a chip-select rise without a strobe empties the count
   a_r8_rise_clears: assert property (@(posedge clk) disable iff (rst)
      (rise_o && !stb_i) |=> (cnt_q == '0));

   // R8: a strobe on the rising edge is taken as the instruction
   a_r8_rise_strobe: assert property (@(posedge clk) disable iff (rst)
      (rise_o && stb_i) |=> (cnt_q == CNT_ONE && insn_q == $past(host_i)));

endmodule

// File: rtl/nvs_shift_lane.sv
module nvs_shift_lane #(
   parameter int BYTE_W = 8,
   parameter int VAL_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_i,
   input  logic              shift_i,
   input  logic [BYTE_W-1:0] din_i,
   output logic [VAL_W-1:0]  acc_o
);

   generate
      if (VAL_W < BYTE_W || (VAL_W % BYTE_W) != 0) begin : g_bad_val
         $error("nvs_shift_lane: VAL_W must be a multiple of BYTE_W");
      end
   endgenerate

   logic [VAL_W-1:0] acc_q, acc_d;

   generate
      if (VAL_W == BYTE_W) begin : g_single
         always_comb acc_d = din_i;
      end else begin : g_multi
         always_comb acc_d = {acc_q[VAL_W-BYTE_W-1:0], din_i};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr_i)
         acc_q <= '0;
      else if (shift_i)
         acc_q <= acc_d;
   end

   assign acc_o = acc_q;

   // R6: newest byte lands in the low byte of the accumulator
   a_r6_low_byte: assert property (@(posedge clk) disable iff (rst)
      (shift_i && !clr_i) |=> (acc_q[BYTE_W-1:0] == $past(din_i)));

endmodule

// File: rtl/nvsram_txn_monitor.sv
module nvsram_txn_monitor
   import nvs_mon_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int VAL_W    = 16,
   parameter int TS_W     = 16,
   parameter int ADDR_W   = 4,
   parameter int ADDR_LSB = 3,
   parameter int CNT_W    = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs,
   input  logic              byte_stb,
   input  logic [7:0]        host_byte,
   input  logic [7:0]        dev_byte,
   output logic              rec_valid,
   output logic [2:0]        rec_kind,
   output logic              rec_addressed,
   output logic [3:0]        rec_addr,
   output logic [15:0]       rec_value,
   output logic [15:0]       rec_start
);

   localparam int LANES    = 2;
   localparam int LANE_DEV = 0;
   localparam int LANE_HST = 1;

   generate
      if (BYTE_W != 8 || VAL_W != 16 || TS_W != 16 || ADDR_W != 4) begin : g_bad_port
         $error("nvsram_txn_monitor: parameters must match the port widths");
      end
   endgenerate

   logic              rise, data_stb, frame_end, multi;
   logic [BYTE_W-1:0] insn;
   logic [TS_W-1:0]   start;
   nvs_kind_e         kind;
   logic [ADDR_W-1:0] addr;
   logic              is_read, is_write;
   logic [VAL_W-1:0]  acc [LANES];
   logic [VAL_W-1:0]  value_sel;

   nvs_frame_tracker #(
      .BYTE_W (BYTE_W),
      .TS_W   (TS_W),
      .CNT_W  (CNT_W)
   ) u_track (
      .clk         (clk),
      .rst         (rst),
      .cs_i        (cs),
      .stb_i       (byte_stb),
      .host_i      (host_byte),
      .rise_o      (rise),
      .data_stb_o  (data_stb),
      .frame_end_o (frame_end),
      .multi_o     (multi),
      .insn_o      (insn),
      .start_o     (start)
   );

   nvs_insn_decode #(
      .BYTE_W   (BYTE_W),
      .ADDR_LSB (ADDR_LSB),
      .ADDR_W   (ADDR_W)
   ) u_dec (
      .insn_i     (insn),
      .kind_o     (kind),
      .addr_o     (addr),
      .is_read_o  (is_read),
      .is_write_o (is_write)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [BYTE_W-1:0] lane_din;
         assign lane_din = (g == LANE_DEV) ? dev_byte : host_byte;
         nvs_shift_lane #(
            .BYTE_W (BYTE_W),
            .VAL_W  (VAL_W)
         ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .clr_i   (rise),
            .shift_i (data_stb),
            .din_i   (lane_din),
            .acc_o   (acc[g])
         );
      end
   endgenerate

   always_comb begin
      if (is_read)
         value_sel = acc[LANE_DEV];
      else if (is_write)
         value_sel = acc[LANE_HST];
      else
         value_sel = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rec_valid     <= 1'b0;
         rec_kind      <= '0;
         rec_addressed <= 1'b0;
         rec_addr      <= '0;
         rec_value     <= '0;
         rec_start     <= '0;
      end else begin
         rec_valid <= frame_end;
         if (frame_end) begin
            rec_kind      <= kind;
            rec_addressed <= multi;
            rec_addr      <= multi ? addr : '0;
            rec_value     <= multi ? value_sel : '0;
            rec_start     <= start;
         end
      end
   end

   // R13: one-cycle pulse
   a_r13_single_pulse: assert property (@(posedge clk) disable iff (rst)
      rec_valid |=> !rec_valid);

   // R13: fields hold between pulses
   a_r13_hold: assert property (@(posedge clk) disable iff (rst)
      !rec_valid |-> $stable({rec_kind, rec_addressed, rec_addr, rec_value, rec_start}));

   // R5: plain commands carry no address or data
   a_r5_plain_empty: assert property (@(posedge clk) disable iff (rst)
      (rec_valid && !rec_addressed) |-> (rec_addr == '0 && rec_value == '0));

   // R7: classes other than read and write report zero
   a_r7_other_zero: assert property (@(posedge clk) disable iff (rst)
      (rec_valid && rec_kind != K_READ && rec_kind != K_WRITE) |-> (rec_value == '0));

   // R11: a closing frame with no byte emits nothing
   a_r11_empty_frame: assert property (@(posedge clk) disable iff (rst)
      ($fell(cs) && !frame_end) |=> !rec_valid);

   // R10: record follows the sampled chip-select fall
   a_r10_after_fall: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> $past(cs, 2) && !$past(cs));

endmodule

// File: tb/test_nvsram_txn_monitor.sv
`timescale 1ns/1ps
module test_nvsram_txn_monitor;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cs = 1'b0;
   logic        byte_stb = 1'b0;
   logic [7:0]  host_byte = '0;
   logic [7:0]  dev_byte = '0;
   logic        rec_valid;
   logic [2:0]  rec_kind;
   logic        rec_addressed;
   logic [3:0]  rec_addr;
   logic [15:0] rec_value;
   logic [15:0] rec_start;

   int n_checks = 0;
   int n_fail   = 0;
   bit started  = 0;
   bit done     = 0;

   always #2.5 clk = ~clk;

   nvsram_txn_monitor i_nvsram_txn_monitor (
      .clk           (clk),
      .rst           (rst),
      .cs            (cs),
      .byte_stb      (byte_stb),
      .host_byte     (host_byte),
      .dev_byte      (dev_byte),
      .rec_valid     (rec_valid),
      .rec_kind      (rec_kind),
      .rec_addressed (rec_addressed),
      .rec_addr      (rec_addr),
      .rec_value     (rec_value),
      .rec_start     (rec_start)
   );

   // Behavioural reference model (transaction view, integers)
   int   m_cyc, m_nb, m_dacc, m_hacc, m_insn, m_st;
   bit   m_prev;
   bit   e_valid, e_addressed;
   int   e_kind, e_addr, e_value, e_start;

   function automatic int kind_of(input int b);
      int m;
      m = b & 'h87;
      if (m < 'h80) return 7;          // R3
      if ((m & 7) >= 6) return 6;      // R2
      return m & 7;                    // R1
   endfunction

   always @(posedge clk) begin
      started <= 1;
      if (rst) begin
         m_cyc = 0; m_nb = 0; m_dacc = 0; m_hacc = 0; m_insn = 0; m_st = 0;
         m_prev = 0; e_valid = 0; e_addressed = 0;
         e_kind = 0; e_addr = 0; e_value = 0; e_start = 0;
      end else begin
         e_valid = 0;
         if (m_prev && !cs && m_nb >= 1) begin          // R10, R11
            e_valid = 1;
            e_kind  = kind_of(m_insn);
            e_start = m_st;                              // R12
            if (m_nb == 1) begin                         // R5
               e_addressed = 0; e_addr = 0; e_value = 0;
            end else begin
               e_addressed = 1;
               e_addr = (m_insn >> 3) & 15;              // R4
               e_value = (e_kind == 6) ? m_dacc : (e_kind == 3) ? m_hacc : 0; // R7
            end
         end
         if (cs && !m_prev) begin m_nb = 0; m_dacc = 0; m_hacc = 0; end  // R8
         if (cs && byte_stb) begin                       // R9: ignored when low
            if (m_nb == 0) begin m_insn = host_byte; m_st = m_cyc; end
            else begin                                   // R6
               m_dacc = ((m_dacc << 8) | dev_byte) & 'hFFFF;
               m_hacc = ((m_hacc << 8) | host_byte) & 'hFFFF;
            end
            m_nb++;
         end
         m_prev = cs;
         m_cyc = (m_cyc + 1) & 'hFFFF;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare every clock, away from the active edge; R13 hold covered here
   always @(negedge clk) begin
      if (started && !done) begin
         check("R10", "rec_valid", int'(rec_valid), int'(e_valid));
         check("R1", "rec_kind", int'(rec_kind), e_kind);
         check("R5", "rec_addressed", int'(rec_addressed), int'(e_addressed));
         check("R4", "rec_addr", int'(rec_addr), e_addr);
         check("R7", "rec_value", int'(rec_value), e_value);
         check("R12", "rec_start", int'(rec_start), e_start);
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   // Frame of nb bytes; byte i at bits [8*i +: 8]; stb_on_rise puts byte 0 on the rise edge
   task automatic frame(input int nb, input logic [63:0] h, input logic [63:0] d,
                        input bit stb_on_rise);
      cs = 1;
      for (int i = 0; i < nb; i++) begin
         if (!(stb_on_rise && i == 0)) begin
            byte_stb = 0; tick(1);
         end
         byte_stb = 1; host_byte = h[8*i +: 8]; dev_byte = d[8*i +: 8];
         tick(1);
      end
      byte_stb = 0;
      tick(1);
      cs = 0;
      tick(3);
   endtask

   initial begin
      tick(3);
      // R13: reset state
      check("R13", "reset rec_valid", int'(rec_valid), 0);
      check("R13", "reset rec_value", int'(rec_value), 0);
      rst = 0;
      tick(2);
      // R1 R2 R5: every masked opcode as a plain command, with address bits set
      for (int op = 0; op < 8; op++) frame(1, 64'(8'h80 | 8'h28 | op), 64'h0, 0);
      // R3: bit 7 clear
      frame(1, 64'h7B, 64'h0, 0);
      // R4 R7: write, host lane; read (both aliases), device lane
      frame(3, 64'h34_12_9B, 64'hAA_BB_CC, 0);
      frame(3, 64'h78_56_F6, 64'hBE_EF_11, 0);
      frame(3, 64'h00_FF_C7, 64'h5A_A5_22, 0);
      // R6: five bytes, oldest data bytes shift out
      frame(5, 64'h44_33_22_11_D3, 64'h99_88_77_66_55, 0);
      frame(5, 64'h44_33_22_11_BE, 64'h99_88_77_66_55, 0);
      // R7: store with data still reports zero
      frame(3, 64'h34_12_B9, 64'hAA_BB_CC, 0);
      // R11: frame with no byte
      frame(0, 64'h0, 64'h0, 0);
      // R9: strobes while deselected
      byte_stb = 1; host_byte = 8'h86; dev_byte = 8'h77; tick(2);
      byte_stb = 0; tick(2);
      frame(1, 64'h84, 64'h0, 0);
      // R8: strobe on the chip-select rise edge
      frame(2, 64'h01_86, 64'hCD_00, 1);
      frame(3, 64'h01_02_83, 64'h0, 1);
      // R8 R12: back-to-back frames, one idle cycle apart
      cs = 1; tick(1); byte_stb = 1; host_byte = 8'h8E; dev_byte = 8'h10; tick(1);
      host_byte = 8'h01; dev_byte = 8'h20; tick(1); byte_stb = 0; cs = 0; tick(1);
      cs = 1; byte_stb = 1; host_byte = 8'hF6; tick(1);
      byte_stb = 0; cs = 0; tick(3);
      // R12: long idle then frame, stamp moves with cycles
      tick(300);
      frame(2, 64'h00_87, 64'h3C_00, 0);
      // R13: reset mid-frame clears outputs
      cs = 1; byte_stb = 1; host_byte = 8'h83; tick(1); byte_stb = 0;
      rst = 1; tick(2); cs = 0;
      check("R13", "reset mid-frame rec_kind", int'(rec_kind), 0);
      rst = 0; tick(4);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL R13 watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule